// File: doc/BRIEF.md
# EDO DRAM Controller with CAS-before-RAS Refresh

This block drives a single rank of EDO DRAM from a synchronous host port. It multiplexes a flat host word address onto a shared row/column address bus, generates the active-low row strobe, column strobe, write enable and output enable, and handles the data pins as a separate output, output-enable and input triple, so the pad ring can build the bidirectional bus. Each host transfer becomes one single-word access: a read that samples the DRAM output near the end of the column strobe, or an early write in which the DRAM never drives its pins.

After reset the controller holds all strobes inactive through a power-up pause (200 µs by default) and then runs eight CAS-before-RAS wake-up cycles before it offers the host port. From then on an internal timer requests one CAS-before-RAS refresh per interval. The interval is the refresh window divided by the number of rows for the chosen geometry. The 4k geometry (12 row bits, 11 column bits) needs 4096 rows in 64 ms. The 8k geometry (13 row bits, 10 column bits) needs 8192 rows in 128 ms. Both give about 15.6 µs.

The host request port is valid/ready. The host raises `host_valid` with address, write flag and write data and must hold all of them until a cycle in which `host_ready` is also high; that cycle is the transfer. `host_ready` is high only while the controller is idle, the wake-up is done and no refresh is pending, so back-pressure lasts for the whole access, its precharge, and any refresh. Read data returns on `host_rdata` with a single-cycle `host_rvalid` strobe that cannot be stalled. Timing parameters must be chosen so that `T_RCD + 1 + T_CAS` cycles cover the row-access time and `T_CAS` cycles cover the column-access time.

Top module: `edo_ctrl`

## Requirements
- R1: While reset is applied and for the first INIT_US*CLK_MHZ cycles after it, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are 1, `dram_dq_oe` is 0 and `host_ready` is 0; the first column strobe falls no more than 4 cycles after that pause.
- R2: After the pause, exactly 8 CAS-before-RAS cycles occur before `host_ready` is first 1.
- R3: A refresh cycle drops `dram_cas_n` while `dram_ras_n` is 1 and `dram_we_n` is 1, drops `dram_ras_n` exactly one cycle later, and holds the row strobe low for T_RAS cycles.
- R4: After wake-up, refreshes follow one another every CLK_MHZ*1000*W/2^ROW_W cycles, with W = 64 for the 4k geometry (GEOM_8K=0) and 128 for the 8k geometry (GEOM_8K=1), give or take one access; a pending refresh is served before a new host request and an access in progress finishes first.
- R5: Host address bits [ROW_W+COL_W-1:COL_W] are the row and bits [COL_W-1:0] the column (12/11 for 4k, 13/10 for 8k); the row is on `dram_addr` when the row strobe falls, the zero-extended column is there when the column strobe falls, and `dram_addr` changes at most once while the row strobe is low in an access.
- R6: In an access the column strobe falls T_RCD+1 cycles after the row strobe and stays low for T_CAS cycles; the row strobe stays low for at least T_RAS cycles and stays high for at least T_RP cycles before it falls again.
- R7: A write is an early write: `dram_we_n` is 0 when the column strobe falls and on every cycle it is low, with `dram_dq_oe` 1, `dram_oe_n` 1 and `dram_dq_o` equal to the accepted write data.
- R8: A read keeps `dram_we_n` at 1 and drives `dram_oe_n` low while the column strobe is low; `dram_dq_i` is sampled in the last cycle of the column strobe and appears on `host_rdata` with `host_rvalid` high for one cycle, in request order.
- R9: A transfer happens on a cycle with `host_valid` and `host_ready` both 1; `host_ready` is 0 in the cycle after a transfer, so only one request is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_MHZ MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Request valid |
| host_ready | output | 1 | Controller can take a request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data |
| host_rvalid | output | 1 | Read data valid, one cycle |
| dram_addr | output | ROW_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_o | output | DATA_W | Data to the DRAM pins |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_o` |
| dram_dq_i | input | DATA_W | Data from the DRAM pins |

## Verification
The bench builds the controller with its default values: 200 MHz, the 4k geometry, the full 200 µs pause and T_RCD=4, T_CAS=5, T_RAS=10, T_RP=6. The true pause and a refresh interval of 3125 cycles fit in the run, so the wake-up count, the gap between successive refreshes and the count over an idle stretch of four intervals are all observed. Random addresses are pulled toward row and column zero and all-ones, so the upper row bits and the whole 11-bit column field pass through the multiplexer against a behavioural EDO memory in the bench.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RCAS,
    S_RRAS,
    S_ROW,
    S_COL,
    S_CAS,
    S_HOLD,
    S_PRE
  } seq_state_t;

  function automatic int row_bits(input int geom_8k);
    return (geom_8k != 0) ? 13 : 12;
  endfunction

  function automatic int col_bits(input int geom_8k);
    return (geom_8k != 0) ? 10 : 11;
  endfunction

  function automatic int window_ms(input int geom_8k);
    return (geom_8k != 0) ? 128 : 64;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/edo_timer.sv
module edo_timer #(
  parameter int INIT_CYC = 40000,
  parameter int REF_CYC  = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  output logic init_done,
  output logic ref_pend
);
  localparam int IW = $clog2(INIT_CYC + 1);
  localparam int RW = $clog2(REF_CYC + 1);
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_CYC - 1);
  localparam logic [RW-1:0] REF_LAST  = RW'(REF_CYC - 1);

  logic [IW-1:0] init_cnt;
  logic [RW-1:0] ref_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt  <= '0;
      init_done <= 1'b0;
      ref_cnt   <= '0;
      ref_pend  <= 1'b0;
    end else if (!init_done) begin
      if (init_cnt == INIT_LAST) init_done <= 1'b1;
      init_cnt <= init_cnt + 1'b1;
    end else if (ref_cnt == REF_LAST) begin
      ref_cnt  <= '0;
      ref_pend <= 1'b1;
    end else begin
      ref_cnt <= ref_cnt + 1'b1;
      if (ref_ack) ref_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/edo_addr_split.sv
module edo_addr_split #(
  parameter int ROW_W = 12,
  parameter int COL_W = 11
) (
  input  logic [ROW_W+COL_W-1:0] flat_addr,
  output logic [ROW_W-1:0]       row,
  output logic [ROW_W-1:0]       col_ext
);
  assign row = flat_addr[ROW_W+COL_W-1:COL_W];

  generate
    if (ROW_W > COL_W) begin : g_pad
      assign col_ext = {{(ROW_W-COL_W){1'b0}}, flat_addr[COL_W-1:0]};
    end else begin : g_flat
      assign col_ext = flat_addr[ROW_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int DATA_W = 64,
  parameter int T_RCD  = 4,
  parameter int T_CAS  = 5,
  parameter int T_RAS  = 10,
  parameter int T_RP   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic              ref_pend,
  output logic              ref_ack,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [ROW_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ROW_W-1:0]  addr,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int CW   = $clog2(max3(T_RCD, T_CAS, T_RP) + 1);
  localparam int AW_C = $clog2(T_RAS + 1);
  localparam logic [CW-1:0]   RCD_LD = CW'(T_RCD - 1);
  localparam logic [CW-1:0]   CAS_LD = CW'(T_CAS - 1);
  localparam logic [CW-1:0]   RP_LD  = CW'(T_RP - 1);
  localparam logic [AW_C-1:0] RAS_LD = AW_C'(T_RAS - 1);
  localparam logic [3:0]      WAKE_N = 4'd8;

  seq_state_t        st;
  logic [CW-1:0]     cnt;
  logic [AW_C-1:0]   ras_cnt;
  logic [3:0]        wake;
  logic              wr_q;
  logic [ROW_W-1:0]  row_q, col_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wake_done, ras_low, col_phase;

  assign wake_done = (wake == WAKE_N);
  assign req_ready = (st == S_IDLE) && init_done && wake_done && !ref_pend;
  assign ref_ack   = (st == S_IDLE) && init_done && (!wake_done || ref_pend);
  assign ras_low   = (st == S_ROW) || (st == S_COL) || (st == S_CAS) ||
                     (st == S_HOLD) || (st == S_RRAS);
  assign col_phase = (st == S_COL) || (st == S_CAS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      ras_cnt  <= '0;
      wake     <= '0;
      wr_q     <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      wdata_q  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (ras_low && ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;
      case (st)
        S_IDLE: begin
          if (ref_ack) begin
            st <= S_RCAS;
            if (!wake_done) wake <= wake + 1'b1;
          end else if (req_valid && req_ready) begin
            st      <= S_ROW;
            cnt     <= RCD_LD;
            ras_cnt <= RAS_LD;
            wr_q    <= req_wr;
            row_q   <= req_row;
            col_q   <= req_col;
            wdata_q <= req_wdata;
          end
        end
        S_RCAS: begin
          st      <= S_RRAS;
          ras_cnt <= RAS_LD;
        end
        S_RRAS, S_HOLD: begin
          if (ras_cnt == '0) begin
            st  <= S_PRE;
            cnt <= RP_LD;
          end
        end
        S_ROW: begin
          if (cnt == '0) st <= S_COL;
          else cnt <= cnt - 1'b1;
        end
        S_COL: begin
          st  <= S_CAS;
          cnt <= CAS_LD;
        end
        S_CAS: begin
          if (cnt == '0) begin
            st <= S_HOLD;
            if (!wr_q) begin
              rd_data  <= dq_i;
              rd_valid <= 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_PRE: begin
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ras_n = !ras_low;
  assign cas_n = !((st == S_CAS) || (st == S_RCAS) || (st == S_RRAS));
  assign we_n  = !(wr_q && col_phase);
  assign oe_n  = !(!wr_q && (st == S_CAS));
  assign dq_oe = wr_q && col_phase;
  assign dq_o  = wdata_q;
  assign addr  = (st == S_ROW) ? row_q : col_q;
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
  import edo_pkg::*;
#(
  parameter int CLK_MHZ = 200,
  parameter int GEOM_8K = 0,
  parameter int INIT_US = 200,
  parameter int DATA_W  = 64,
  parameter int T_RCD   = 4,
  parameter int T_CAS   = 5,
  parameter int T_RAS   = 10,
  parameter int T_RP    = 6,
  localparam int ROW_W  = row_bits(GEOM_8K),
  localparam int COL_W  = col_bits(GEOM_8K),
  localparam int HA_W   = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_wr,
  input  logic [HA_W-1:0]   host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic [ROW_W-1:0]  dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DATA_W-1:0] dram_dq_o,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_i
);
  localparam int INIT_CYC = INIT_US * CLK_MHZ;
  localparam int REF_CYC  = (CLK_MHZ * 1000 * window_ms(GEOM_8K)) >> ROW_W;

  logic             init_done, ref_pend, ref_ack;
  logic [ROW_W-1:0] req_row, req_col;

  edo_timer #(.INIT_CYC(INIT_CYC), .REF_CYC(REF_CYC)) i_timer (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack),
    .init_done(init_done), .ref_pend(ref_pend)
  );

  edo_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) i_split (
    .flat_addr(host_addr), .row(req_row), .col_ext(req_col)
  );

  edo_seq #(
    .ROW_W(ROW_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_RAS(T_RAS), .T_RP(T_RP)
  ) i_seq (
    .clk(clk), .rst_n(rst_n),
    .init_done(init_done), .ref_pend(ref_pend), .ref_ack(ref_ack),
    .req_valid(host_valid), .req_ready(host_ready), .req_wr(host_wr),
    .req_row(req_row), .req_col(req_col), .req_wdata(host_wdata),
    .addr(dram_addr), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
    .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_o(dram_dq_o),
    .dq_oe(dram_dq_oe), .dq_i(dram_dq_i),
    .rd_data(host_rdata), .rd_valid(host_rvalid)
  );
endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk #(
  parameter int PW   = 12,
  parameter int T_RP = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          dq_oe,
  input logic [PW-1:0] addr,
  input logic          host_ready,
  input logic          rd_valid
);
  logic [3:0] wake_seen;
  logic [7:0] hi_cnt;
  logic       cas_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_seen <= '0;
      hi_cnt    <= '0;
      cas_q     <= 1'b1;
    end else begin
      cas_q <= cas_n;
      if (cas_q && !cas_n && ras_n && wake_seen != 4'd8) wake_seen <= wake_seen + 1'b1;
      if (!ras_n) hi_cnt <= '0;
      else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R3
  cbr_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && ras_n) |-> we_n);

  // R8
  oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !cas_n && !ras_n));

  // R7
  early_write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && !cas_n) |-> (dq_oe && oe_n));

  // R5
  col_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n) && !ras_n) |-> $stable(addr));

  // R8
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R2
  no_early_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (wake_seen == 4'd8));

  // R6
  precharge_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= 8'(T_RP)));
endmodule

bind edo_ctrl edo_ctrl_chk #(.PW(ROW_W), .T_RP(T_RP)) i_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe), .addr(dram_addr),
  .host_ready(host_ready), .rd_valid(host_rvalid)
);

// File: tb/test_edo_ctrl.sv
`timescale 1ns/1ps
module test_edo_ctrl;
  localparam int CLK_MHZ = 200, INIT_US = 200;
  localparam int T_RCD = 4, T_CAS = 5, T_RAS = 10, T_RP = 6;
  localparam int RW = 12, CW = 11, AW = 23, DW = 64;
  localparam int INIT_CYC = INIT_US * CLK_MHZ;
  localparam int REF_CYC  = CLK_MHZ * 1000 * 64 / 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic h_valid = 1'b0, h_wr = 1'b0;
  logic [AW-1:0] h_addr = '0;
  logic [DW-1:0] h_wdata = '0;
  logic host_ready, host_rvalid;
  logic [DW-1:0] host_rdata;
  logic [RW-1:0] dram_addr;
  logic ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] dq_o, dq_i, drive_word;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  edo_ctrl i_edo_ctrl (
    .clk(clk), .rst_n(rst_n), .host_valid(h_valid), .host_ready(host_ready),
    .host_wr(h_wr), .host_addr(h_addr), .host_wdata(h_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .dram_addr(dram_addr),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_dq_o(dq_o), .dram_dq_oe(dq_oe), .dram_dq_i(dq_i)
  );

  function automatic logic [DW-1:0] init_pat(input logic [AW-1:0] a);
    return {a, 9'h1F3, ~a, 9'h0A5};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // behavioural EDO memory and scoreboard
  logic [DW-1:0] dmem [int];
  logic [DW-1:0] smem [int];
  logic [DW-1:0] exp_q [$];
  logic [RW-1:0] cur_row, cur_col, lrow;
  logic [DW-1:0] cur_wdata;

  assign dq_i = (!oe_n && !cas_n) ? drive_word : '0;

  // port monitor
  int cyc = 0, nref = 0, last_ref = 0, ref_cas_cyc = 0;
  int ras_fall_cyc = 0, ras_rise_cyc = 0, cas_fall_cyc = 0, addr_chg = 0, nrise = 0;
  bit p_ras = 1, p_cas = 1, in_ref = 0, seen_ready = 0;
  logic [RW-1:0] p_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      int key;
      cyc++;
      if (cas_n == 1'b0 && p_cas && ras_n) begin
        chk(we_n == 1'b1, "R3 refresh WE", 64'(we_n), 64'd1);
        nref++;
        ref_cas_cyc = cyc;
        if (nref == 1)
          chk(cyc >= INIT_CYC && cyc <= INIT_CYC + 4, "R1 pause length", 64'(cyc), 64'(INIT_CYC));
        if (nref >= 10)
          chk(cyc - last_ref <= REF_CYC + 40 && cyc - last_ref >= REF_CYC - 40,
              "R4 refresh gap", 64'(cyc - last_ref), 64'(REF_CYC));
        last_ref = cyc;
      end
      if (!ras_n && p_ras) begin
        if (!cas_n) begin
          chk(cyc - ref_cas_cyc == 1, "R3 CAS before RAS", 64'(cyc - ref_cas_cyc), 64'd1);
          in_ref = 1;
        end else begin
          chk(dram_addr == cur_row, "R5 row address", 64'(dram_addr), 64'(cur_row));
          lrow = dram_addr;
          in_ref = 0;
          addr_chg = 0;
        end
        if (nrise > 0)
          chk(cyc - ras_rise_cyc >= T_RP, "R6 precharge", 64'(cyc - ras_rise_cyc), 64'(T_RP));
        ras_fall_cyc = cyc;
      end
      if (!ras_n && !p_ras && dram_addr != p_addr) addr_chg++;
      if (!cas_n && p_cas && !ras_n) begin
        chk(cyc - ras_fall_cyc == T_RCD + 1, "R6 RAS to CAS", 64'(cyc - ras_fall_cyc), 64'(T_RCD + 1));
        chk(dram_addr == cur_col, "R5 column address", 64'(dram_addr), 64'(cur_col));
        cas_fall_cyc = cyc;
        key = int'({lrow[RW-1:0], dram_addr[CW-1:0]});
        if (!we_n) begin
          chk(dq_oe && oe_n, "R7 early write drivers", {62'd0, dq_oe, oe_n}, 64'd3);
          chk(dq_o == cur_wdata, "R7 write data", dq_o, cur_wdata);
          dmem[key] = dq_o;
        end else begin
          chk(oe_n == 1'b0, "R8 read OE", 64'(oe_n), 64'd0);
          drive_word = dmem.exists(key) ? dmem[key] : init_pat(AW'(key));
        end
      end
      if (!cas_n && !ras_n && !we_n)
        chk(oe_n == 1'b1, "R7 OE high during write", 64'(oe_n), 64'd1);
      if (cas_n && !p_cas && !ras_n && !in_ref)
        chk(cyc - cas_fall_cyc == T_CAS, "R6 CAS width", 64'(cyc - cas_fall_cyc), 64'(T_CAS));
      if (ras_n && !p_ras) begin
        chk(cyc - ras_fall_cyc >= T_RAS, "R6 RAS active", 64'(cyc - ras_fall_cyc), 64'(T_RAS));
        if (in_ref)
          chk(cyc - ras_fall_cyc == T_RAS, "R3 refresh RAS width", 64'(cyc - ras_fall_cyc), 64'(T_RAS));
        else
          chk(addr_chg <= 1, "R5 one address change", 64'(addr_chg), 64'd1);
        ras_rise_cyc = cyc;
        nrise++;
      end
      if (host_ready && !seen_ready) begin
        chk(nref == 8, "R2 wake-up refresh count", 64'(nref), 64'd8);
        seen_ready = 1;
      end
      if (host_rvalid) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected read data", host_rdata, 64'd0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(host_rdata == e, "R8 read data", host_rdata, e);
        end
      end
      p_ras = ras_n;
      p_cas = cas_n;
      p_addr = dram_addr;
    end
  end

  task automatic xfer(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d);
    @(negedge clk);
    h_valid = 1'b1; h_wr = w; h_addr = a; h_wdata = d;
    while (!host_ready) @(negedge clk);
    cur_row = a[AW-1:CW];
    cur_col = {1'b0, a[CW-1:0]};
    cur_wdata = d;
    if (w) smem[int'(a)] = d;
    else exp_q.push_back(smem.exists(int'(a)) ? smem[int'(a)] : init_pat(a));
    @(negedge clk);
    h_valid = 1'b0;
    chk(host_ready == 1'b0, "R9 one request in flight", 64'(host_ready), 64'd0);
  endtask

  function automatic logic [AW-1:0] pick_addr();
    logic [RW-1:0] r;
    logic [CW-1:0] c;
    case ($urandom % 4)
      0: r = '0;
      1: r = '1;
      default: r = RW'($urandom % 3);
    endcase
    case ($urandom % 4)
      0: c = '0;
      1: c = '1;
      default: c = CW'($urandom % 3);
    endcase
    return {r, c};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 64'(cyc), 64'd0);
    finish_run();
  end

  initial begin
    int n0;
    void'($urandom(32'd24681));
    repeat (4) @(negedge clk);
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF, "R1 strobes idle in reset", 64'({ras_n, cas_n, we_n, oe_n}), 64'hF);
    chk(!dq_oe && !host_ready, "R1 no drive or ready in reset", {62'd0, dq_oe, host_ready}, 64'd0);
    rst_n = 1'b1;
    repeat (INIT_CYC - 10) @(negedge clk);
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF, "R1 strobes idle in pause", 64'({ras_n, cas_n, we_n, oe_n}), 64'hF);
    chk(!host_ready, "R1 not ready in pause", 64'(host_ready), 64'd0);
    // directed corners: extreme row and column
    xfer({12'hFFF, 11'h7FF}, 1'b1, 64'hDEAD_BEEF_0123_4567);
    xfer({12'hFFF, 11'h7FF}, 1'b0, '0);
    xfer({12'h000, 11'h000}, 1'b0, '0);
    xfer({12'h000, 11'h000}, 1'b1, 64'h0F0F_F0F0_1111_2222);
    xfer({12'h000, 11'h000}, 1'b0, '0);
    xfer({12'h800, 11'h400}, 1'b0, '0);
    // random mix
    for (int i = 0; i < 300; i++)
      xfer(pick_addr(), 1'($urandom % 2), {$urandom, $urandom});
    // idle stretch: refresh count over four intervals
    repeat (20) @(negedge clk);
    n0 = nref;
    repeat (4 * REF_CYC) @(negedge clk);
    chk(nref - n0 >= 3 && nref - n0 <= 5, "R4 refreshes in idle window", 64'(nref - n0), 64'd4);
    for (int i = 0; i < 100; i++)
      xfer(pick_addr(), 1'($urandom % 2), {$urandom, $urandom});
    repeat (50) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all reads returned", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule